// File: doc/BRIEF.md
# Banked Register File Address Decoder

This block sits on the data side of a small 8-bit controller core. It forms an 8-bit effective file address and decides what that address reaches. It then completes the read or the write.

In direct mode the address is built from two parts. A held bank bit supplies the top bit. A 7-bit field from the current instruction supplies the lower seven bits. In indirect mode the full 8-bit file-select pointer is the address, and both the bank bit and the instruction field are disregarded.

The low part of each bank selects one of the special-function registers. The block reports that register's index, and the read data comes from the special-function register side. The remainder of each bank is general-purpose RAM. Both banks share one physical copy of that RAM. Only part of the RAM region is populated with storage.

Top module: `banked_file_decoder`

## Requirements
- R1: A synchronous active-high `rst` clears the bank bit, and it has priority over `bank_we`. After reset, a direct access at field 0x03 reports `sfr_idx` = 0x03.
- R2: In direct mode (`indirect_sel`=0) the effective address is {bank bit, `fld_addr`}. The bank bit is address bit 7.
- R3: In indirect mode (`indirect_sel`=1) the effective address is `fsr_ptr[7:0]`, whatever the values of the bank bit and `fld_addr`.
- R4: Offsets 0x00 to 0x0B (address bits 6:0) in either bank give `sfr_hit`=1 and `gpr_hit`=0. They also give `sfr_idx` = {address bit 7, offset[3:0]} and `rd_data` = `sfr_rdata`.
- R5: Offsets 0x0C to 0x7F in either bank give `gpr_hit`=1 and `sfr_hit`=0.
- R6: A general-purpose offset reached with address bit 7 set reaches the same byte as that offset with bit 7 clear. For example, 0x8C and 0x0C reach the same byte.
- R7: With `wr_en`=1 at an implemented general-purpose offset (0x0C to 0x4F), `wr_data` is stored on the rising clock edge. The read data is combinational from the current address, so it shows the stored byte from the cycle after that edge.
- R8: At the unimplemented general-purpose offsets 0x50 to 0x7F, `rd_data` is 0x00 and writes change no stored byte.
- R9: With `bank_we`=1 and `rst`=0, the bank bit takes `bank_din` on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the bank bit |
| bank_we | input | 1 | Load enable for the bank bit |
| bank_din | input | 1 | New bank bit value |
| indirect_sel | input | 1 | 1 selects the pointer as the address, 0 selects bank plus field |
| fld_addr | input | 7 | File address field from the instruction |
| fsr_ptr | input | 8 | File-select pointer used in indirect mode |
| wr_en | input | 1 | Write strobe for the addressed byte |
| wr_data | input | 8 | Data to write |
| sfr_rdata | input | 8 | Read data returned by the special-function register side |
| rd_data | output | 8 | Read data for the current address |
| sfr_hit | output | 1 | Address falls in the special-function region |
| sfr_idx | output | 5 | Bank bit and offset of the special-function register hit |
| gpr_hit | output | 1 | Address falls in the general-purpose region |

## Verification
Two things can happen in the same cycle: a write, and a combinational read of the byte being written. The bench holds one address with `wr_en` high. It samples `rd_data` before the edge and expects the old byte, then samples again after the edge and expects the new byte.

A bank-bit load can also coincide with a direct special-function access. In that case `sfr_idx` must show the old bank until the edge and the new bank after it.

// File: rtl/fda_pkg.sv
`timescale 1ns/1ps
package fda_pkg;
  localparam int DEF_DATA_W    = 8;
  localparam int DEF_OFS_W     = 7;
  localparam int DEF_SFR_COUNT = 12;
  localparam int DEF_GPR_DEPTH = 68;

  typedef enum logic [1:0] {
    RGN_SFR      = 2'd0,
    RGN_GPR_RAM  = 2'd1,
    RGN_GPR_VOID = 2'd2
  } region_e;
endpackage

// File: rtl/fda_bank_reg.sv
`timescale 1ns/1ps
module fda_bank_reg (
  input  logic clk,
  input  logic rst,
  input  logic bank_we,
  input  logic bank_din,
  output logic bank_q
);
  always_ff @(posedge clk) begin
    if (rst)          bank_q <= 1'b0;
    else if (bank_we) bank_q <= bank_din;
  end
endmodule

// File: rtl/fda_addr_mux.sv
`timescale 1ns/1ps
module fda_addr_mux #(
  parameter int OFS_W = 7
) (
  input  logic             indirect_sel,
  input  logic             bank_q,
  input  logic [OFS_W-1:0] fld_addr,
  input  logic [OFS_W:0]   fsr_ptr,
  output logic [OFS_W:0]   eff_addr
);
  always_comb begin
    if (indirect_sel) eff_addr = fsr_ptr;
    else              eff_addr = {bank_q, fld_addr};
  end
endmodule

// File: rtl/fda_region_decode.sv
`timescale 1ns/1ps
module fda_region_decode
  import fda_pkg::*;
#(
  parameter int OFS_W     = 7,
  parameter int SFR_COUNT = 12,
  parameter int GPR_DEPTH = 68,
  localparam int SFR_IW   = $clog2(SFR_COUNT),
  localparam int RAM_AW   = $clog2(GPR_DEPTH)
) (
  input  logic [OFS_W:0]    eff_addr,
  output region_e           region,
  output logic [SFR_IW:0]   sfr_idx,
  output logic [RAM_AW-1:0] ram_idx
);
  localparam int GPR_TOP = SFR_COUNT + GPR_DEPTH - 1;
  localparam logic [OFS_W-1:0] LO_V = OFS_W'(SFR_COUNT);
  localparam logic [OFS_W-1:0] HI_V = OFS_W'(GPR_TOP);

  logic [OFS_W-1:0] ofs;
  logic [OFS_W-1:0] rel;

  assign ofs     = eff_addr[OFS_W-1:0];
  assign rel     = ofs - LO_V;
  assign ram_idx = RAM_AW'(rel);
  assign sfr_idx = {eff_addr[OFS_W], ofs[SFR_IW-1:0]};

  always_comb begin
    if (ofs < LO_V)       region = RGN_SFR;
    else if (ofs <= HI_V) region = RGN_GPR_RAM;
    else                  region = RGN_GPR_VOID;
  end
endmodule

// File: rtl/fda_gpr_ram.sv
`timescale 1ns/1ps
module fda_gpr_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 68,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/banked_file_decoder.sv
`timescale 1ns/1ps
module banked_file_decoder
  import fda_pkg::*;
#(
  parameter int DATA_W    = DEF_DATA_W,
  parameter int OFS_W     = DEF_OFS_W,
  parameter int SFR_COUNT = DEF_SFR_COUNT,
  parameter int GPR_DEPTH = DEF_GPR_DEPTH,
  localparam int SFR_IW   = $clog2(SFR_COUNT),
  localparam int RAM_AW   = $clog2(GPR_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bank_we,
  input  logic              bank_din,
  input  logic              indirect_sel,
  input  logic [OFS_W-1:0]  fld_addr,
  input  logic [OFS_W:0]    fsr_ptr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] sfr_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              sfr_hit,
  output logic [SFR_IW:0]   sfr_idx,
  output logic              gpr_hit
);
  logic              bank_q;
  logic [OFS_W:0]    eff_addr;
  region_e           region;
  logic [RAM_AW-1:0] ram_idx;
  logic [DATA_W-1:0] ram_rdata;
  logic              gpr_impl;

  fda_bank_reg u_bank (
    .clk      (clk),
    .rst      (rst),
    .bank_we  (bank_we),
    .bank_din (bank_din),
    .bank_q   (bank_q)
  );

  fda_addr_mux #(.OFS_W(OFS_W)) u_amux (
    .indirect_sel (indirect_sel),
    .bank_q       (bank_q),
    .fld_addr     (fld_addr),
    .fsr_ptr      (fsr_ptr),
    .eff_addr     (eff_addr)
  );

  fda_region_decode #(
    .OFS_W     (OFS_W),
    .SFR_COUNT (SFR_COUNT),
    .GPR_DEPTH (GPR_DEPTH)
  ) u_dec (
    .eff_addr (eff_addr),
    .region   (region),
    .sfr_idx  (sfr_idx),
    .ram_idx  (ram_idx)
  );

  assign gpr_impl = (region == RGN_GPR_RAM);
  assign sfr_hit  = (region == RGN_SFR);
  assign gpr_hit  = (region != RGN_SFR);

  fda_gpr_ram #(.DATA_W(DATA_W), .DEPTH(GPR_DEPTH)) u_ram (
    .clk   (clk),
    .we    (wr_en & gpr_impl),
    .idx   (ram_idx),
    .wdata (wr_data),
    .rdata (ram_rdata)
  );

  always_comb begin
    if (sfr_hit)       rd_data = sfr_rdata;
    else if (gpr_impl) rd_data = ram_rdata;
    else               rd_data = '0;
  end
endmodule

// File: rtl/fda_checker.sv
`timescale 1ns/1ps
module fda_checker #(
  parameter int DATA_W = 8,
  parameter int OFS_W  = 7,
  parameter int SFR_IW = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bank_we,
  input logic              bank_din,
  input logic              indirect_sel,
  input logic [OFS_W-1:0]  fld_addr,
  input logic [OFS_W:0]    fsr_ptr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] sfr_rdata,
  input logic [DATA_W-1:0] rd_data,
  input logic              sfr_hit,
  input logic [SFR_IW:0]   sfr_idx,
  input logic              gpr_hit,
  input logic              bank_q,
  input logic [OFS_W:0]    eff_addr,
  input logic              gpr_impl
);
  // R1
  bank_clear_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !bank_q);

  // R9
  bank_load_chk: assert property (@(posedge clk) disable iff (rst)
    bank_we |=> (bank_q == $past(bank_din)));

  // R2
  direct_index_chk: assert property (@(posedge clk) disable iff (rst)
    (!indirect_sel && sfr_hit) |-> (sfr_idx == {bank_q, fld_addr[SFR_IW-1:0]}));

  // R3
  indirect_index_chk: assert property (@(posedge clk) disable iff (rst)
    (indirect_sel && sfr_hit) |-> (sfr_idx == {fsr_ptr[OFS_W], fsr_ptr[SFR_IW-1:0]}));

  // R4
  sfr_data_chk: assert property (@(posedge clk) disable iff (rst)
    sfr_hit |-> (!gpr_hit && rd_data == sfr_rdata));

  // R5
  region_cover_chk: assert property (@(posedge clk) disable iff (rst)
    !sfr_hit |-> gpr_hit);

  // R7
  write_visible_chk: assert property (@(posedge clk) disable iff (rst)
    ((wr_en && gpr_impl) ##1 (eff_addr == $past(eff_addr))) |-> (rd_data == $past(wr_data)));

  // R8
  void_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (gpr_hit && !gpr_impl) |-> (rd_data == '0));
endmodule

bind banked_file_decoder fda_checker #(
  .DATA_W (DATA_W),
  .OFS_W  (OFS_W),
  .SFR_IW (SFR_IW)
) u_fda_chk (
  .clk          (clk),
  .rst          (rst),
  .bank_we      (bank_we),
  .bank_din     (bank_din),
  .indirect_sel (indirect_sel),
  .fld_addr     (fld_addr),
  .fsr_ptr      (fsr_ptr),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .sfr_rdata    (sfr_rdata),
  .rd_data      (rd_data),
  .sfr_hit      (sfr_hit),
  .sfr_idx      (sfr_idx),
  .gpr_hit      (gpr_hit),
  .bank_q       (bank_q),
  .eff_addr     (eff_addr),
  .gpr_impl     (gpr_impl)
);

// File: tb/tb_banked_file_decoder.sv
`timescale 1ns/1ps
module tb_banked_file_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bank_we = 1'b0;
  logic       bank_din = 1'b0;
  logic       indirect_sel = 1'b0;
  logic [6:0] fld_addr = '0;
  logic [7:0] fsr_ptr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] sfr_rdata = 8'hA5;
  logic [7:0] rd_data;
  logic       sfr_hit;
  logic [4:0] sfr_idx;
  logic       gpr_hit;

  int unsigned tests = 0;
  int unsigned fails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  banked_file_decoder dut (
    .clk          (clk),
    .rst          (rst),
    .bank_we      (bank_we),
    .bank_din     (bank_din),
    .indirect_sel (indirect_sel),
    .fld_addr     (fld_addr),
    .fsr_ptr      (fsr_ptr),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .sfr_rdata    (sfr_rdata),
    .rd_data      (rd_data),
    .sfr_hit      (sfr_hit),
    .sfr_idx      (sfr_idx),
    .gpr_hit      (gpr_hit)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic go_direct(input logic [6:0] f);
    @(negedge clk);
    indirect_sel = 1'b0; fld_addr = f; wr_en = 1'b0; bank_we = 1'b0;
    #1;
  endtask

  task automatic go_indirect(input logic [7:0] p, input logic [6:0] f);
    @(negedge clk);
    indirect_sel = 1'b1; fsr_ptr = p; fld_addr = f; wr_en = 1'b0; bank_we = 1'b0;
    #1;
  endtask

  task automatic set_bank(input logic b);
    @(negedge clk);
    bank_we = 1'b1; bank_din = b;
    @(posedge clk); #1;
    bank_we = 1'b0;
  endtask

  task automatic write_direct(input logic [6:0] f, input logic [7:0] d);
    @(negedge clk);
    indirect_sel = 1'b0; fld_addr = f; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic write_indirect(input logic [7:0] p, input logic [7:0] d);
    @(negedge clk);
    indirect_sel = 1'b1; fsr_ptr = p; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1; bank_we = 1'b1; bank_din = 1'b1;
    repeat (2) @(posedge clk);
    #1; rst = 1'b0; bank_we = 1'b0;
    go_direct(7'h03);
    chk("R1 sfr_idx after reset", 16'(sfr_idx), 16'h03);
    chk("R1 sfr_hit after reset", 16'(sfr_hit), 16'h1);
  endtask

  task automatic t_sfr_region;
    sfr_rdata = 8'hA5;
    go_direct(7'h00);
    chk("R4 sfr_hit at 0x00", 16'({sfr_hit, gpr_hit}), 16'h2);
    chk("R4 rd_data from sfr side", 16'(rd_data), 16'hA5);
    go_direct(7'h0B);
    chk("R4 sfr_idx at 0x0B", 16'(sfr_idx), 16'h0B);
    chk("R4 hits at 0x0B", 16'({sfr_hit, gpr_hit}), 16'h2);
    go_direct(7'h0C);
    chk("R5 hits at 0x0C", 16'({sfr_hit, gpr_hit}), 16'h1);
    go_direct(7'h7F);
    chk("R5 hits at 0x7F", 16'({sfr_hit, gpr_hit}), 16'h1);
  endtask

  task automatic t_bank_load;
    set_bank(1'b1);
    go_direct(7'h05);
    chk("R9 R2 sfr_idx bank1", 16'(sfr_idx), 16'h15);
    set_bank(1'b0);
    go_direct(7'h05);
    chk("R9 R2 sfr_idx bank0", 16'(sfr_idx), 16'h05);
  endtask

  task automatic t_write_read;
    write_direct(7'h0C, 8'h5A);
    go_direct(7'h0C);
    chk("R7 readback 0x0C", 16'(rd_data), 16'h5A);
    write_direct(7'h4F, 8'hC3);
    go_direct(7'h4F);
    chk("R7 readback 0x4F", 16'(rd_data), 16'hC3);
  endtask

  task automatic t_mirror;
    set_bank(1'b1);
    go_direct(7'h0C);
    chk("R6 bank1 view of 0x0C", 16'(rd_data), 16'h5A);
    write_direct(7'h20, 8'h77);
    set_bank(1'b0);
    go_direct(7'h20);
    chk("R6 bank0 view of bank1 write", 16'(rd_data), 16'h77);
  endtask

  task automatic t_indirect;
    set_bank(1'b0);
    go_indirect(8'h8C, 7'h03);
    chk("R3 indirect gpr hit", 16'({sfr_hit, gpr_hit}), 16'h1);
    chk("R3 indirect mirrored read", 16'(rd_data), 16'h5A);
    go_indirect(8'h85, 7'h40);
    chk("R3 indirect sfr_idx uses pointer bit7", 16'(sfr_idx), 16'h15);
    write_indirect(8'h30, 8'h11);
    go_direct(7'h30);
    chk("R3 indirect write seen direct", 16'(rd_data), 16'h11);
  endtask

  task automatic t_unimpl;
    write_direct(7'h50, 8'hFF);
    go_direct(7'h50);
    chk("R8 read 0x50", 16'(rd_data), 16'h00);
    chk("R8 gpr_hit 0x50", 16'(gpr_hit), 16'h1);
    go_direct(7'h7F);
    chk("R8 read 0x7F", 16'(rd_data), 16'h00);
    go_direct(7'h4F);
    chk("R8 0x4F untouched", 16'(rd_data), 16'hC3);
    go_direct(7'h0C);
    chk("R8 0x0C untouched", 16'(rd_data), 16'h5A);
  endtask

  task automatic t_same_cycle;
    write_direct(7'h40, 8'h00);
    @(negedge clk);
    indirect_sel = 1'b0; fld_addr = 7'h40; wr_data = 8'h99; wr_en = 1'b1;
    #1;
    chk("R7 old data before edge", 16'(rd_data), 16'h00);
    @(posedge clk); #1;
    chk("R7 new data after edge", 16'(rd_data), 16'h99);
    wr_en = 1'b0;
    @(negedge clk);
    fld_addr = 7'h02; bank_we = 1'b1; bank_din = 1'b1;
    #1;
    chk("R9 old bank before edge", 16'(sfr_idx), 16'h02);
    @(posedge clk); #1;
    chk("R9 new bank after edge", 16'(sfr_idx), 16'h12);
    bank_we = 1'b0;
    set_bank(1'b0);
  endtask

  initial begin
    t_reset();
    t_sfr_region();
    t_bank_load();
    t_write_read();
    t_mirror();
    t_indirect();
    t_unimpl();
    t_same_cycle();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule